// File: doc/BRIEF.md
# Bit-Order-Configurable SPI Register Slave

This block is a serial control port slave. Through it a host reads and writes a file of 128 byte-wide registers over a SPI-style link. The link has a serial clock, an active-low chip select and a data line. A separate data-out line can be used when four wires are wanted. Every access opens with an instruction byte that holds a read/write flag and a 7-bit register address. After it, any number of data bytes follow for as long as chip select stays low. After each data byte the internal address moves to a neighbouring register.

Bit 6 of register 0x00 is the bit-order control. It picks the order in which the bits of the instruction and data bytes travel, and it also picks the direction of the multibyte address counter. The block runs on a system clock. It samples the serial clock, chip select and data line through two-stage synchronizers, so the serial clock must stay high and stay low for at least six system-clock periods each. The bidirectional data pin is split into an input, an output value and an output enable, and the pad combines them.

Top module: `spiRegSlave`

## Requirements
- R1: After reset all registers hold 0x00 and the port works MSB-first. sdioOe and sdo are 0 until a read transfer reaches its data phase.
- R2: In MSB-first mode the instruction arrives as R/W, then A6 down to A0. R/W = 1 is a read and R/W = 0 is a write.
- R3: In LSB-first mode the instruction arrives as A0 up to A6, then R/W last, with the same read/write encoding.
- R4: Each data byte travels bit 7 first in MSB-first mode and bit 0 first in LSB-first mode. This holds for both writes and reads.
- R5: In MSB-first mode the first data byte uses the instruction address. Each later byte uses the address one lower, and the count wraps from 0x00 to 0x7F.
- R6: In LSB-first mode each later byte uses the address one higher, and the count wraps from 0x7F to 0x00.
- R7: Bit 6 of register 0x00 (1 = LSB-first) sets the order only from the next transfer on. The rest of the transfer that writes it keeps the old order and the old counting direction.
- R8: A data byte cut short because chip select rises before its eighth rising edge is discarded. The addressed register keeps its value.
- R9: Inputs are taken on rising SCLK edges, and read data changes only after falling edges. The first read bit is valid before the ninth rising edge. With fourWire = 0, read data appears on sdioOut and sdioOe is 1 only in the data phase of a read.
- R10: With fourWire = 1, read data appears on sdo and sdioOe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 12 times the serial clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| sdioIn | input | 1 | Serial data from the host (pad input of the data line) |
| fourWire | input | 1 | 1 = read data on sdo, 0 = read data on the shared data line |
| sdioOut | output | 1 | Read data value for the shared data line |
| sdioOe | output | 1 | Output enable for the shared data line |
| sdo | output | 1 | Separate serial data output used in four-wire mode |

## Verification
A wrong address counter first shows up in the second byte of a multibyte access. That byte is written to, or read from, the wrong neighbour, so the error appears in a read-back one byte time later. A bit-order latch that changes at the wrong moment makes a byte arrive bit-reversed. If it changes in the middle of a transfer, the error appears in that same transfer. If it changes late, the error appears on the first byte of the next transfer. A bit counter that does not clear on chip select is seen as a shifted instruction in the next access, and its data then goes to a wrong register at once.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  // strobes handed from the control to the datapath, one system-clock wide
  typedef struct packed {
    logic shiftEn;    // rising SCLK edge inside a transfer
    logic instrDone;  // eighth bit of the instruction taken
    logic byteDone;   // eighth bit of a data byte taken
    logic driveEdge;  // falling SCLK edge where read data advances
    logic xferEnd;    // chip select just released
    logic inData;     // level: data phase of a transfer
    logic rxBit;      // synchronized serial input bit
  } strbT;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sdioIn,
  output strbT strb
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [1:0] sclkSync, csSync, dinSync;
  logic sclkPrev, csActPrev, inData;
  logic [CNT_W-1:0] bitCnt;
  logic csActive, rise, fall, lastBit;

  assign csActive = ~csSync[1];
  assign rise     = csActive & sclkSync[1] & ~sclkPrev;
  assign fall     = csActive & ~sclkSync[1] & sclkPrev;
  assign lastBit  = (bitCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync  <= '0;
      csSync    <= '1;
      dinSync   <= '0;
      sclkPrev  <= 1'b0;
      csActPrev <= 1'b0;
      bitCnt    <= '0;
      inData    <= 1'b0;
    end else begin
      sclkSync  <= {sclkSync[0], sclk};
      csSync    <= {csSync[0], csN};
      dinSync   <= {dinSync[0], sdioIn};
      sclkPrev  <= sclkSync[1];
      csActPrev <= csActive;
      if (!csActive) begin
        bitCnt <= '0;
        inData <= 1'b0;
      end else if (rise) begin
        bitCnt <= lastBit ? '0 : bitCnt + CNT_W'(1);
        if (lastBit) inData <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.shiftEn   = rise;
    strb.instrDone = rise & lastBit & ~inData;
    strb.byteDone  = rise & lastBit & inData;
    strb.driveEdge = fall & inData & (bitCnt != '0);
    strb.xferEnd   = csActPrev & ~csActive;
    strb.inData    = inData;
    strb.rxBit     = dinSync[1];
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.instrDone, strb.byteDone, strb.xferEnd}));

  assert_instr_opens_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.instrDone |=> (inData || !csActive));

  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == '0 && !inData));
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int ORDER_BIT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  strbT strb,
  input  logic fourWire,
  output logic sdioOut,
  output logic sdioOe,
  output logic sdo
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [BYTE_W-1:0] regFile [DEPTH];
  logic [BYTE_W-1:0] rxShift, rxNext, txShift;
  logic [ADDR_W-1:0] addr, stepAddr, instrAddr;
  logic isRead, lsbAct, instrRead, txBit, readOut;

  // both orders leave the flag in the top bit and the address below it
  assign rxNext    = lsbAct ? {strb.rxBit, rxShift[BYTE_W-1:1]}
                            : {rxShift[BYTE_W-2:0], strb.rxBit};
  assign instrRead = rxNext[BYTE_W-1];
  assign instrAddr = rxNext[ADDR_W-1:0];
  assign stepAddr  = lsbAct ? addr + ADDR_W'(1) : addr - ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (strb.byteDone && !isRead) begin
      regFile[addr] <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      addr    <= '0;
      isRead  <= 1'b0;
      lsbAct  <= 1'b0;
    end else begin
      if (strb.shiftEn) rxShift <= rxNext;
      if (strb.instrDone) begin
        addr   <= instrAddr;
        isRead <= instrRead;
        if (instrRead) txShift <= regFile[instrAddr];
      end else if (strb.byteDone) begin
        addr <= stepAddr;
        if (isRead) txShift <= regFile[stepAddr];
      end else if (strb.driveEdge) begin
        txShift <= lsbAct ? (txShift >> 1) : (txShift << 1);
      end
      if (strb.xferEnd) begin
        lsbAct <= regFile[0][ORDER_BIT];
        isRead <= 1'b0;
      end
    end
  end

  assign txBit   = lsbAct ? txShift[0] : txShift[BYTE_W-1];
  assign readOut = strb.inData & isRead;
  assign sdioOe  = readOut & ~fourWire;
  assign sdioOut = sdioOe & txBit;
  assign sdo     = readOut & fourWire & txBit;

  assert_order_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xferEnd |=> $stable(lsbAct));

  assert_addr_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteDone && !lsbAct) |=> (addr == $past(addr) - ADDR_W'(1)));

  assert_addr_up_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteDone && lsbAct) |=> (addr == $past(addr) + ADDR_W'(1)));

  assert_oe_after_instr_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdioOe) |-> ($past(strb.instrDone) || $past(fourWire)));

  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> (sdo == 1'b0));
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave #(
  parameter int ADDR_W    = 7,
  parameter int ORDER_BIT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sdioIn,
  input  logic fourWire,
  output logic sdioOut,
  output logic sdioOe,
  output logic sdo
);
  localparam int BYTE_W = ADDR_W + 1;

  spiRegPkg::strbT strb;

  spiRegCtrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn), .strb(strb)
  );

  spiRegDatapath #(.ADDR_W(ADDR_W), .ORDER_BIT(ORDER_BIT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .fourWire(fourWire),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdo(sdo)
  );
endmodule

// File: tb/spiRegSlave_tb_top.sv
module spiRegSlave_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, sdioIn = 1'b0, fourWire = 1'b0;
  logic sdioOut, sdioOe, sdo;

  int checks = 0, errors = 0, oeMiss = 0;
  bit done = 0;
  bit tbLsb = 0;
  logic [7:0] mdl [128];
  logic [7:0] wrBuf [256];
  logic [7:0] rdBuf [256];

  always #2.5 clk = ~clk;

  spiRegSlave dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .fourWire(fourWire), .sdioOut(sdioOut), .sdioOe(sdioOe), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // sends nb bits of b in the current order, returns the bits seen on the output
  task automatic xByte(input logic [7:0] b, input int nb, input bit expOe, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nb; i++) begin
      int idx = tbLsb ? i : 7 - i;
      @(negedge clk) sdioIn = b[idx];
      repeat (HALF - 1) @(negedge clk);
      got[idx] = fourWire ? sdo : sdioOut;
      if (sdioOe !== expOe) oeMiss++;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // full transfer; cut > 0 sends only that many bits of the first data byte
  task automatic xfer(input bit rd, input logic [6:0] a, input int n, input int cut);
    logic [7:0] got;
    logic [6:0] ad;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    xByte({rd, a}, 8, 1'b0, got);
    if (cut > 0) xByte(wrBuf[0], cut, 1'b0, got);
    else
      for (int k = 0; k < n; k++) begin
        xByte(rd ? 8'h00 : wrBuf[k], 8, rd && !fourWire, got);
        rdBuf[k] = got;
      end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    if (!rd && cut == 0) begin
      ad = a;
      for (int k = 0; k < n; k++) begin
        mdl[ad] = wrBuf[k];
        ad = tbLsb ? ad + 7'd1 : ad - 7'd1;
      end
    end
    tbLsb = mdl[0][6];
  endtask

  task automatic readChk(input logic [6:0] a, input int n, input string req);
    logic [6:0] ad;
    xfer(1'b1, a, n, 0);
    ad = a;
    for (int k = 0; k < n; k++) begin
      chk(rdBuf[k] === mdl[ad], req, int'(rdBuf[k]), int'(mdl[ad]));
      ad = tbLsb ? ad + 7'd1 : ad - 7'd1;
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdioOe === 1'b0 && sdo === 1'b0, "R1 idle outputs", int'({sdioOe, sdo}), 0);
    readChk(7'h00, 1, "R1 reset reg0");
    readChk(7'h55, 1, "R1 reset reg55");

    // R2 R4: MSB-first single-byte write and read at every address
    for (int a = 0; a < 128; a++) begin
      wrBuf[0] = 8'((a * 37 + 11) & 8'hFF);
      xfer(1'b0, 7'(a), 1, 0);
    end
    for (int a = 0; a < 128; a++) readChk(7'(a), 1, "R2 R4 msb sweep");
    chk(oeMiss == 0, "R9 sdioOe window", oeMiss, 0);

    // R5: decrementing multibyte write with wrap 0x00 -> 0x7F
    wrBuf[0] = 8'h13; wrBuf[1] = 8'h24; wrBuf[2] = 8'h9C;
    xfer(1'b0, 7'h01, 3, 0);
    readChk(7'h01, 3, "R5 msb multibyte");
    readChk(7'h7F, 1, "R5 wrap target");

    // R8: cut-short data byte is dropped
    wrBuf[0] = 8'hFF;
    xfer(1'b0, 7'h10, 1, 5);
    readChk(7'h10, 1, "R8 partial byte");

    // R10: four-wire read
    fourWire = 1'b1;
    oeMiss = 0;
    readChk(7'h10, 1, "R10 sdo read");
    readChk(7'h01, 3, "R10 sdo multibyte");
    chk(oeMiss == 0, "R10 sdioOe low", oeMiss, 0);
    fourWire = 1'b0;

    // R7: switching to LSB-first keeps old order for the rest of the transfer
    wrBuf[0] = 8'h40; wrBuf[1] = 8'h5A;
    xfer(1'b0, 7'h00, 2, 0);
    chk(tbLsb == 1'b1, "R7 model order", int'(tbLsb), 1);
    readChk(7'h7F, 1, "R7 second byte old order");
    readChk(7'h00, 1, "R7 reg0 lsb read");

    // R3 R4 R6: LSB-first 128-byte write and read from 0x00
    for (int k = 0; k < 128; k++)
      wrBuf[k] = 8'((k * 53 + 7) & 8'hFF) | ((k == 0) ? 8'h40 : 8'h00);
    xfer(1'b0, 7'h00, 128, 0);
    oeMiss = 0;
    readChk(7'h00, 128, "R3 R4 R6 lsb sweep");
    chk(oeMiss == 0, "R9 lsb sdioOe window", oeMiss, 0);

    // R6: incrementing wrap 0x7F -> 0x00
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h4C;
    xfer(1'b0, 7'h7E, 3, 0);
    readChk(7'h7F, 2, "R6 lsb wrap");
    readChk(7'h7E, 1, "R6 lsb start");

    // R7: back to MSB-first on the following transfer
    wrBuf[0] = 8'h00;
    xfer(1'b0, 7'h00, 1, 0);
    chk(tbLsb == 1'b0, "R7 model back", int'(tbLsb), 0);
    readChk(7'h00, 1, "R7 reg0 msb read");
    readChk(7'h7F, 2, "R7 R5 msb after switch");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule